// File: doc/BRIEF.md
# Change-of-State Input Port Controller

This block samples a 48-line input port and lets a host read it through a byte-wide register window of eight addresses. The lines are split into six groups of eight, and each group has its own read address. Every line passes through a two-stage synchronizer before anything looks at it.

The block also watches each group for a change of state. Any rising or falling transition on any line of a group counts as a change. When a group whose interrupt is enabled changes, a per-group flag is latched and the interrupt output rises. The host finds the cause by reading the status byte. That read also clears the flags.

The status address is shared. A write to it loads the per-group enable mask. A read from it returns the group flags together with an active-low interrupt indicator. The usual bring-up sequence is to write 0 to the status address, which disables every group, and then read it once, which leaves the flags clean.

Top module: `cos_input_port`

## Requirements
- R1: After reset `irq` is 0, and a read of offset 7 returns 8'h40: all flags 0, bit 6 at 1, bit 7 at 0.
- R2: A read of offset 0, 1, 2, 4, 5 or 6 returns the synchronized lines of group 0, 1, 2, 3, 4 or 5 in that order. Group g holds lines 8g (bit 0) to 8g+7 (bit 7).
- R3: A read of offset 3 always returns 0.
- R4: A rising or a falling transition on any line of group g sets flag g, provided enable bit g is 1. While any flag is set, `irq` is 1 and bit 6 of the offset 7 read value is 0. Bits 0 to 5 of the read value are flags 0 to 5.
- R5: A transition in a group whose enable bit is 0 sets no flag and does not raise `irq`.
- R6: A read of offset 7 returns the current flags and then clears them. With no new transition, the following read returns 8'h40 and `irq` is 0.
- R7: A transition detected in the same cycle as a status read is not lost. Its flag is set after the read, so that read returns the old value and the next read returns the new flag.
- R8: A write to offset 7 loads bits 0 to 5 as the enable mask. Clearing an enable bit also clears that group's pending flag, and the other flags are kept.
- R9: A write to any offset other than 7 changes neither the enable mask, nor the flags, nor the group data.
- R10: A change on an input line appears in the group read value after two clock edges. The matching flag and `irq` appear after three clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pins | input | 48 | Asynchronous input lines |
| addr | input | 3 | Register offset within the window |
| wrEn | input | 1 | Write strobe, one cycle per access |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe. At offset 7 it clears the flags |
| rdData | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request, high while any flag is set |

## Verification
The assertions assume that `addr` is steady while a strobe is high, and that the host never raises `wrEn` and `rdEn` in the same cycle. The stimulus keeps to both by driving one access per task call, on the falling clock edge. The assertions also assume that an input line holds each new level for at least three cycles, so that each transition is seen exactly once. The bench waits four cycles after every change of the inputs, both in the random loop and in the directed cases.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = 3'd7;
  localparam logic [ADDR_W-1:0] HOLE_ADDR   = 3'd3;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic              enableWr;   // load the enable mask
    logic              statusClr;  // status read: clear the flags
    logic              statusSel;  // read mux selects the status byte
    logic              groupSel;   // read mux selects a line group
    logic [ADDR_W-1:0] groupIdx;   // group number for a group read
  } cosStrobe_t;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int WIDTH = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/cos_ctrl.sv
module cos_ctrl
  import cos_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output cosStrobe_t        strobe
);
  always_comb begin
    strobe           = '0;
    strobe.statusSel = (addr == STATUS_ADDR);
    strobe.enableWr  = wrEn && (addr == STATUS_ADDR);
    strobe.statusClr = rdEn && (addr == STATUS_ADDR);
    strobe.groupSel  = (addr != STATUS_ADDR) && (addr != HOLE_ADDR);
    // offsets above the hole are shifted down by one
    strobe.groupIdx  = (addr > HOLE_ADDR) ? addr - 3'd1 : addr;
  end
endmodule

// File: rtl/cos_datapath.sv
module cos_datapath
  import cos_pkg::*;
#(
  parameter int GROUPS = 6,
  parameter int GBITS  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [GROUPS*GBITS-1:0] pins,
  input  cosStrobe_t              strobe,
  input  logic [GROUPS-1:0]       wrMask,
  output logic [GBITS-1:0]        rdData,
  output logic                    irq
);
  localparam int LINES = GROUPS * GBITS;

  logic [LINES-1:0]  syncPins;
  logic [LINES-1:0]  prevPins;
  logic [GROUPS-1:0] edgeGroup;
  logic [GROUPS-1:0] enableReg;
  logic [GROUPS-1:0] enableNext;
  logic [GROUPS-1:0] flags;
  logic [GROUPS-1:0] flagsNext;
  logic [GBITS-1:0]  groupWord [GROUPS];
  logic [GBITS-1:0]  statusByte;

  cos_sync #(.WIDTH(LINES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (pins),
    .dout(syncPins)
  );

  // A group has changed when any of its lines differs from the previous cycle
  for (genvar g = 0; g < GROUPS; g++) begin : g_group
    assign groupWord[g] = syncPins[g*GBITS +: GBITS];
    assign edgeGroup[g] = |(syncPins[g*GBITS +: GBITS] ^ prevPins[g*GBITS +: GBITS]);
  end

  assign enableNext = strobe.enableWr ? wrMask : enableReg;
  // New edges win over a clear in the same cycle; a disabled group drops its flag
  assign flagsNext  = enableNext & (edgeGroup | (flags & ~{GROUPS{strobe.statusClr}}));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevPins  <= '0;
      enableReg <= '0;
      flags     <= '0;
    end else begin
      prevPins  <= syncPins;
      enableReg <= enableNext;
      flags     <= flagsNext;
    end
  end

  assign irq = |flags;

  always_comb begin
    statusByte             = '0;
    statusByte[GROUPS-1:0] = flags;
    statusByte[GROUPS]     = ~irq;
  end

  always_comb begin
    rdData = '0;
    if (strobe.statusSel) begin
      rdData = statusByte;
    end else if (strobe.groupSel) begin
      for (int g = 0; g < GROUPS; g++) begin
        if (strobe.groupIdx == ADDR_W'(g)) rdData = groupWord[g];
      end
    end
  end
endmodule

// File: rtl/cos_input_port.sv
module cos_input_port
  import cos_pkg::*;
#(
  parameter int GROUPS = 6,
  parameter int GBITS  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [GROUPS*GBITS-1:0] pins,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wrEn,
  input  logic [GBITS-1:0]        wrData,
  input  logic                    rdEn,
  output logic [GBITS-1:0]        rdData,
  output logic                    irq
);
  cosStrobe_t strobe;
  logic       unusedWrBits;

  assign unusedWrBits = ^wrData[GBITS-1:GROUPS];

  cos_ctrl u_ctrl (
    .addr  (addr),
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .strobe(strobe)
  );

  cos_datapath #(.GROUPS(GROUPS), .GBITS(GBITS)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .pins  (pins),
    .strobe(strobe),
    .wrMask(wrData[GROUPS-1:0]),
    .rdData(rdData),
    .irq   (irq)
  );
endmodule

// File: rtl/cos_input_port_chk.sv
module cos_input_port_chk #(
  parameter int GROUPS = 6,
  parameter int GBITS  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        addr,
  input logic              wrEn,
  input logic [GBITS-1:0]  wrData,
  input logic              rdEn,
  input logic [GBITS-1:0]  rdData,
  input logic              irq,
  input logic [GROUPS-1:0] flags,
  input logic [GROUPS-1:0] enableMask,
  input logic [GROUPS-1:0] edgeGroup
);
  // R5: a flag only appears for a group that changed in the previous cycle
  assert_no_spurious_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (flags & ~$past(flags) & ~$past(edgeGroup)) == '0);

  // R8: no pending flag survives in a disabled group
  assert_flag_needs_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (flags & ~enableMask) == '0);

  // R8: writing an all-zero enable mask silences the interrupt
  assert_disable_quiets_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd7 && wrData[GROUPS-1:0] == '0) |=> !irq);

  // R6: after a status read, only groups that changed in that cycle stay flagged
  assert_clear_on_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && addr == 3'd7) |=> (flags & ~$past(edgeGroup)) == '0);

  // R3: the unused offset reads as zero
  assert_hole_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 3'd3) |-> (rdData == '0));
endmodule

bind cos_input_port cos_input_port_chk #(.GROUPS(GROUPS), .GBITS(GBITS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .addr      (addr),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .rdEn      (rdEn),
  .rdData    (rdData),
  .irq       (irq),
  .flags     (u_dp.flags),
  .enableMask(u_dp.enableReg),
  .edgeGroup (u_dp.edgeGroup)
);

// File: tb/sim_cos_input_port.sv
`timescale 1ns/1ps
module sim_cos_input_port;
  localparam int GROUPS = 6;
  localparam int GBITS  = 8;
  localparam int LINES  = GROUPS * GBITS;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [LINES-1:0] pins = '0;
  logic [2:0]       addr = '0;
  logic             wrEn = 1'b0;
  logic [7:0]       wrData = '0;
  logic             rdEn = 1'b0;
  logic [7:0]       rdData;
  logic             irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // Bench model of the block's state
  logic [5:0]       mEnable = '0;
  logic [5:0]       mFlags = '0;
  logic [LINES-1:0] mPins = '0;

  always #2 clk = ~clk;

  cos_input_port #(.GROUPS(GROUPS), .GBITS(GBITS)) u0 (
    .clk(clk), .rstN(rstN), .pins(pins), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] groupAddr(input int g);
    return (g < 3) ? 3'(g) : 3'(g + 1);
  endfunction

  function automatic logic [5:0] changedGroups(input logic [LINES-1:0] a, input logic [LINES-1:0] b);
    logic [5:0] c;
    for (int g = 0; g < GROUPS; g++) c[g] = |(a[g*GBITS +: GBITS] ^ b[g*GBITS +: GBITS]);
    return c;
  endfunction

  function automatic logic [7:0] expStatus();
    return {1'b0, ~(|mFlags), mFlags};
  endfunction

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    if (a == 3'd7) begin
      mEnable = d[5:0];
      mFlags  = mFlags & mEnable;
    end
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
    if (a == 3'd7) mFlags = '0;
  endtask

  task automatic setPins(input logic [LINES-1:0] p);
    @(negedge clk);
    pins = p;
    repeat (4) @(negedge clk);
    mFlags = mFlags | (changedGroups(mPins, p) & mEnable);
    mPins  = p;
  endtask

  task automatic checkStatus(input string req);
    logic [7:0] d;
    logic [7:0] e;
    e = expStatus();
    busRead(3'd7, d);
    check(req, d, e);
  endtask

  task automatic checkGroup(input string req, input int g);
    logic [7:0] d;
    busRead(groupAddr(g), d);
    check(req, d, mPins[g*GBITS +: GBITS]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [LINES-1:0] nxt;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state, then the init sequence
    #1 check("R1 irq", irq, 0);
    checkStatus("R1 status");
    busWrite(3'd7, 8'h00);
    busRead(3'd7, d);

    // R2 group mapping, interrupts disabled (R5)
    setPins(48'hA5_5A_3C_C3_0F_F0);
    for (int g = 0; g < GROUPS; g++) checkGroup("R2 group", g);
    check("R5 irq disabled", irq, 0);
    checkStatus("R5 status disabled");

    // R3 the hole reads zero
    busRead(3'd3, d);
    check("R3 hole", d, 0);

    // R10 latency, rising edge on line 0 with group 0 enabled
    busWrite(3'd7, 8'h01);
    @(negedge clk);
    addr = 3'd0;
    nxt = mPins ^ 48'h1;
    pins = nxt;
    @(negedge clk); #1;
    check("R10 data 1 edge", rdData, mPins[7:0]);
    check("R10 irq 1 edge", irq, 0);
    @(negedge clk); #1;
    check("R10 data 2 edges", rdData, nxt[7:0]);
    check("R10 irq 2 edges", irq, 0);
    @(negedge clk); #1;
    check("R10 irq 3 edges", irq, 1);
    mPins = nxt; mFlags = 6'h01;
    check("R4 rise status", expStatus(), 8'h01);
    checkStatus("R4 rise status");
    #1 check("R6 irq cleared", irq, 0);
    checkStatus("R6 empty status");

    // R4 falling edge
    setPins(mPins ^ 48'h1);
    check("R4 fall irq", irq, 1);
    checkStatus("R4 fall status");

    // R9 writes elsewhere are ignored
    busWrite(3'd0, 8'hFF);
    busWrite(3'd5, 8'h3F);
    setPins(mPins ^ 48'h0000_0000_FF00);
    check("R9 irq", irq, 0);
    checkStatus("R9 status");
    checkGroup("R9 group data", 1);

    // R8 clearing an enable drops only that flag
    busWrite(3'd7, 8'h3F);
    setPins(mPins ^ 48'h0010_0004_0000);
    check("R8 pre irq", irq, 1);
    busWrite(3'd7, 8'h2F);
    check("R8 model", mFlags, 6'h04);
    checkStatus("R8 keep others");
    busWrite(3'd7, 8'h3F);
    setPins(mPins ^ 48'h0000_0100_0000);
    busWrite(3'd7, 8'h00);
    #1 check("R8 irq off", irq, 0);
    checkStatus("R8 all cleared");

    // R7 edge in the same cycle as a status read
    busWrite(3'd7, 8'h3F);
    @(negedge clk);
    nxt = mPins ^ 48'h8000_0000_0000;
    pins = nxt;
    @(negedge clk);
    @(negedge clk);
    addr = 3'd7; rdEn = 1'b1;
    #1 check("R7 read before flag", rdData, 8'h40);
    @(negedge clk);
    rdEn = 1'b0;
    mPins = nxt; mFlags = 6'h20;
    #1 check("R7 irq kept", irq, 1);
    checkStatus("R7 status kept");

    // Random mix
    for (int i = 0; i < 80; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[1:0] == 2'd0) busWrite(3'd7, 8'($urandom));
      nxt = mPins;
      for (int g = 0; g < GROUPS; g++)
        if ($urandom % 2 == 0) nxt[g*GBITS +: GBITS] = nxt[g*GBITS +: GBITS] ^ 8'($urandom);
      setPins(nxt);
      check("R4 random irq", irq, {31'd0, |mFlags});
      if (r[3:2] == 2'd0) checkStatus("R6 random status");
      else checkGroup("R2 random group", int'(r[10:8]) % GROUPS);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule